// File: doc/BRIEF.md
# Byte-Lane SRAM Host Port with Store-Busy Gating

This block is a clocked model of the host side of a 16-bit-word static RAM whose controls are active low: a chip select, a write strobe, an output enable and two byte-lane enables. It decodes each sampled cycle into a read, a byte-masked write or nothing. It holds the word array, and it produces read data together with a separate drive enable for each byte lane of the bidirectional data bus. The bus is split into an input, an output and the enable.

An active-low busy line from the nonvolatile store sequencer gates every new access. While busy is low, no read drives the bus and no write may begin. A write that was already running when busy fell is still allowed to finish. Each committed write raises a one-cycle `write_done` pulse, which the sequencer uses to mark the array as modified. The analog access time is modelled as the parameter `RD_LAT`, a count of clock cycles.

The controller has four states. `S_IDLE` means no access. `S_RD_WAIT` counts the access latency. `S_RD_VALID` drives read data. `S_WR` means a write strobe is active. The transitions are:
- start-write: from `S_IDLE`, or from a read state when its read condition fails, into `S_WR`.
- start-read: from `S_IDLE` into `S_RD_WAIT`.
- latency-done: from `S_RD_WAIT` into `S_RD_VALID`.
- address-move: from `S_RD_VALID` back to `S_RD_WAIT`, or `S_RD_WAIT` reloading itself.
- read-drop: from either read state into `S_IDLE`.
- write-end: from `S_WR` into `S_IDLE`, committing the word.

Top module: `sram_host_port`

## Requirements
- R1: While `rst_n` is low, and in the cycle after it is released, `dq_oe` is 2'b00 and `write_done` is 0.
- R2: A read is decoded on a clock edge where `ce_n`=0, `oe_n`=0, `we_n`=1 and `busy_n`=1. If that condition and the address stay steady, the word at `addr` appears on `dq_out` with `dq_oe` set after RD_LAT+1 rising edges, and not after RD_LAT edges.
- R3: A write is decoded on a clock edge where `ce_n`=0, `we_n`=0 and `busy_n`=1. `ub_n`=0 enables bits 15:8 and `lb_n`=0 enables bits 7:0. A disabled lane keeps its previous contents.
- R4: The written word is the `dq_in` and lane enables sampled on the last edge on which the strobe was still active. The commit happens on the first edge that sees `we_n` or `ce_n` high. `write_done` is 1 for exactly the one cycle after that edge, and 0 while the strobe is still active.
- R5: During a read, a new `addr` alone turns `dq_oe` off after the next edge. The new word then appears RD_LAT+1 edges after the change, with no control edge needed.
- R6: An edge that sees `ce_n` high, `oe_n` high, `we_n` low or `busy_n` low makes `dq_oe` 2'b00 after that edge.
- R7: `dq_oe[1]` covers bits 15:8 and follows `ub_n`. `dq_oe[0]` covers bits 7:0 and follows `lb_n`. A disabled lane is never driven.
- R8: A write strobe first seen while `busy_n`=0 commits nothing, so the stored word is unchanged and `write_done` stays 0.
- R9: A read condition held while `busy_n`=0 never drives the bus. Once `busy_n` returns high, the read completes after RD_LAT+1 edges.
- R10: A write already in `S_WR` when `busy_n` falls still commits at its end and pulses `write_done`.
- R11: A write ended by `ce_n` rising while `we_n` stays low commits and pulses `write_done` in the same way as one ended by `we_n`.
- R12: The address is `ADDR_W` bits wide, and every word from 0 to 2**ADDR_W-1 is separately addressable. A full-size build sets ADDR_W to 18, which gives 262,144 words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ce_n | input | 1 | Chip select, active low |
| we_n | input | 1 | Write strobe, active low |
| oe_n | input | 1 | Output enable, active low |
| ub_n | input | 1 | Upper lane (bits 15:8) enable, active low |
| lb_n | input | 1 | Lower lane (bits 7:0) enable, active low |
| busy_n | input | 1 | Store sequencer busy, active low; low blocks new access |
| addr | input | ADDR_W | Word address |
| dq_in | input | 16 | Write data from the bus |
| dq_out | output | 16 | Read data to the bus |
| dq_oe | output | 2 | Per-lane bus drive enable, bit 1 for bits 15:8 |
| write_done | output | 1 | One-cycle pulse per committed write |

## Verification
The assertions assume that the control inputs are synchronous to `clk` and settle before each rising edge. They also assume that `addr` stays steady for as long as a write strobe is held, because the write address is captured when the write is entered. The bench changes every input on the falling edge only. It keeps the address fixed for the whole of each write, and it raises the strobes before it moves to a new address.

// File: rtl/sram_port_pkg.sv
package sram_port_pkg;
    localparam int LANE_W = 8;
    localparam int LANES  = 2;
    localparam int WORD_W = LANE_W * LANES;

    typedef enum logic [1:0] {
        S_IDLE     = 2'd0,
        S_RD_WAIT  = 2'd1,
        S_RD_VALID = 2'd2,
        S_WR       = 2'd3
    } port_state_e;
endpackage

// File: rtl/sram_port_ctrl.sv
module sram_port_ctrl
    import sram_port_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int RD_LAT = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ce_n,
    input  logic                we_n,
    input  logic                oe_n,
    input  logic                busy_n,
    input  logic [LANES-1:0]    lane_en,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [WORD_W-1:0]   dq_in,
    output port_state_e         state_o,
    output logic [ADDR_W-1:0]   rd_addr,
    output logic [ADDR_W-1:0]   wr_addr,
    output logic [WORD_W-1:0]   wr_data,
    output logic [LANES-1:0]    wr_mask,
    output logic                commit,
    output logic                write_done
);
    localparam int CNT_W = (RD_LAT > 1) ? $clog2(RD_LAT) : 1;
    localparam logic [CNT_W-1:0] LAT_LOAD = CNT_W'(RD_LAT - 1);

    port_state_e       state_q, state_d;
    logic [CNT_W-1:0]  cnt_q, cnt_d;
    logic [ADDR_W-1:0] rd_addr_q;
    logic              rd_req, wr_req, wr_hold, addr_moved, addr_load;
    logic              wr_enter, wr_keep;

    assign rd_req     = !ce_n && !oe_n && we_n && busy_n;
    assign wr_req     = !ce_n && !we_n && busy_n;
    assign wr_hold    = !ce_n && !we_n;
    assign addr_moved = (addr != rd_addr_q);

    // next-state process
    always_comb begin
        state_d   = state_q;
        cnt_d     = cnt_q;
        addr_load = 1'b0;
        unique case (state_q)
            S_IDLE: begin
                if (wr_req) begin
                    state_d = S_WR;
                end else if (rd_req) begin
                    state_d   = S_RD_WAIT;
                    cnt_d     = LAT_LOAD;
                    addr_load = 1'b1;
                end
            end
            S_RD_WAIT: begin
                if (!rd_req) begin
                    state_d = wr_req ? S_WR : S_IDLE;
                end else if (addr_moved) begin
                    cnt_d     = LAT_LOAD;
                    addr_load = 1'b1;
                end else if (cnt_q == '0) begin
                    state_d = S_RD_VALID;
                end else begin
                    cnt_d = cnt_q - 1'b1;
                end
            end
            S_RD_VALID: begin
                if (!rd_req) begin
                    state_d = wr_req ? S_WR : S_IDLE;
                end else if (addr_moved) begin
                    state_d   = S_RD_WAIT;
                    cnt_d     = LAT_LOAD;
                    addr_load = 1'b1;
                end
            end
            S_WR: begin
                if (!wr_hold) begin
                    state_d = S_IDLE;
                end
            end
            default: state_d = S_IDLE;
        endcase
    end

    // state register process
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= S_IDLE;
            cnt_q     <= '0;
            rd_addr_q <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            if (addr_load) begin
                rd_addr_q <= addr;
            end
        end
    end

    assign wr_enter = (state_q != S_WR) && (state_d == S_WR);
    assign wr_keep  = (state_q == S_WR) && wr_hold;
    assign commit   = (state_q == S_WR) && !wr_hold;

    // output process: write capture and completion pulse
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_addr    <= '0;
            wr_data    <= '0;
            wr_mask    <= '0;
            write_done <= 1'b0;
        end else begin
            write_done <= commit;
            if (wr_enter) begin
                wr_addr <= addr;
            end
            if (wr_enter || wr_keep) begin
                wr_data <= dq_in;
                wr_mask <= lane_en;
            end
        end
    end

    assign state_o = state_q;
    assign rd_addr = rd_addr_q;
endmodule

// File: rtl/sram_lane_array.sv
module sram_lane_array
    import sram_port_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic [LANES-1:0]  we_lane,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [WORD_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [WORD_W-1:0] rd_data
);
    localparam int DEPTH = 1 << ADDR_W;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] mem_q [DEPTH];

        always_ff @(posedge clk) begin
            if (we_lane[g]) begin
                mem_q[wr_addr] <= wr_data[g*LANE_W +: LANE_W];
            end
        end

        assign rd_data[g*LANE_W +: LANE_W] = mem_q[rd_addr];
    end
endmodule

// File: rtl/sram_lane_drive.sv
module sram_lane_drive
    import sram_port_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              valid,
    input  logic [LANES-1:0]  lane_en,
    input  logic [WORD_W-1:0] rd_data,
    output logic [WORD_W-1:0] dq_out,
    output logic [LANES-1:0]  dq_oe
);
    logic [LANES-1:0] lane_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lane_q <= '0;
        end else begin
            lane_q <= lane_en;
        end
    end

    for (genvar g = 0; g < LANES; g++) begin : g_drv
        assign dq_oe[g] = valid && lane_q[g];
        assign dq_out[g*LANE_W +: LANE_W] =
            dq_oe[g] ? rd_data[g*LANE_W +: LANE_W] : '0;
    end
endmodule

// File: rtl/sram_host_port.sv
module sram_host_port
    import sram_port_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int RD_LAT = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic              ub_n,
    input  logic              lb_n,
    input  logic              busy_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [15:0]       dq_in,
    output logic [15:0]       dq_out,
    output logic [1:0]        dq_oe,
    output logic              write_done
);
    port_state_e       state;
    logic [LANES-1:0]  lane_en;
    logic [ADDR_W-1:0] rd_addr, wr_addr;
    logic [WORD_W-1:0] wr_data, rd_data;
    logic [LANES-1:0]  wr_mask;
    logic              commit;

    assign lane_en = ~{ub_n, lb_n};

    sram_port_ctrl #(.ADDR_W(ADDR_W), .RD_LAT(RD_LAT)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
        .busy_n(busy_n), .lane_en(lane_en), .addr(addr), .dq_in(dq_in),
        .state_o(state), .rd_addr(rd_addr), .wr_addr(wr_addr),
        .wr_data(wr_data), .wr_mask(wr_mask), .commit(commit),
        .write_done(write_done)
    );

    sram_lane_array #(.ADDR_W(ADDR_W)) u_array (
        .clk(clk), .we_lane({LANES{commit}} & wr_mask), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data)
    );

    sram_lane_drive u_drive (
        .clk(clk), .rst_n(rst_n), .valid(state == S_RD_VALID),
        .lane_en(lane_en), .rd_data(rd_data), .dq_out(dq_out), .dq_oe(dq_oe)
    );
endmodule

// File: rtl/sram_host_port_chk.sv
module sram_host_port_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       ce_n,
    input logic       we_n,
    input logic       oe_n,
    input logic       ub_n,
    input logic       lb_n,
    input logic       busy_n,
    input logic [1:0] dq_oe,
    input logic       write_done
);
    p_reset_quiet_r1: assert property (@(posedge clk)
        !rst_n |=> (dq_oe == 2'b00 && !write_done));

    p_drive_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ce_n || oe_n || !we_n || !busy_n) |=> (dq_oe == 2'b00));

    p_upper_lane_r7: assert property (@(posedge clk) disable iff (!rst_n)
        dq_oe[1] |-> !$past(ub_n));

    p_lower_lane_r7: assert property (@(posedge clk) disable iff (!rst_n)
        dq_oe[0] |-> !$past(lb_n));

    p_done_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        write_done |=> !write_done);

    p_done_at_end_r4: assert property (@(posedge clk) disable iff (!rst_n)
        write_done |-> ($past(ce_n) || $past(we_n)));
endmodule

bind sram_host_port sram_host_port_chk u_chk (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
    .ub_n(ub_n), .lb_n(lb_n), .busy_n(busy_n), .dq_oe(dq_oe),
    .write_done(write_done)
);

// File: tb/sram_host_port_tb_top.sv
module sram_host_port_tb_top;
    localparam int ADDR_W = 10;
    localparam int RD_LAT = 3;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
    logic              ub_n = 1'b0, lb_n = 1'b0, busy_n = 1'b1;
    logic [ADDR_W-1:0] addr = '0;
    logic [15:0]       dq_in = '0;
    logic [15:0]       dq_out;
    logic [1:0]        dq_oe;
    logic              write_done;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    sram_host_port #(.ADDR_W(ADDR_W), .RD_LAT(RD_LAT)) dut_i (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
        .ub_n(ub_n), .lb_n(lb_n), .busy_n(busy_n), .addr(addr),
        .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe),
        .write_done(write_done)
    );

    task automatic check(input bit ok, input string req,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle_bus();
        ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1; ub_n = 1'b0; lb_n = 1'b0;
    endtask

    task automatic write_word(input logic [ADDR_W-1:0] a, input logic [15:0] d,
                              input logic ub, input logic lb, output logic done);
        addr = a; dq_in = d; ub_n = ub; lb_n = lb; ce_n = 1'b0; we_n = 1'b0;
        @(negedge clk);
        we_n = 1'b1;
        @(negedge clk);
        done = write_done;
        idle_bus();
        @(negedge clk);
    endtask

    task automatic read_word(input logic [ADDR_W-1:0] a, input logic ub,
                             input logic lb, output logic [15:0] d,
                             output logic [1:0] oe, output logic [1:0] early);
        addr = a; ub_n = ub; lb_n = lb; ce_n = 1'b0; oe_n = 1'b0;
        repeat (RD_LAT) @(negedge clk);
        early = dq_oe;
        @(negedge clk);
        d = dq_out;
        oe = dq_oe;
        idle_bus();
        @(negedge clk);
    endtask

    task automatic t_reset();
        check(dq_oe == 2'b00, "R1 dq_oe in reset", 32'(dq_oe), 0);
        check(write_done == 1'b0, "R1 write_done in reset", 32'(write_done), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(dq_oe == 2'b00 && !write_done, "R1 after release",
              {29'd0, dq_oe, write_done}, 0);
    endtask

    task automatic t_write_read();
        logic done; logic [15:0] d; logic [1:0] oe, early;
        write_word(10'd3, 16'hA55A, 1'b0, 1'b0, done);
        check(done, "R3 write_done full write", 32'(done), 1);
        read_word(10'd3, 1'b0, 1'b0, d, oe, early);
        check(early == 2'b00, "R2 not driven after RD_LAT edges", 32'(early), 0);
        check(oe == 2'b11 && d == 16'hA55A, "R2 read data",
              {14'd0, oe, d}, {14'd0, 2'b11, 16'hA55A});
    endtask

    task automatic t_byte_mask();
        logic done; logic [15:0] d; logic [1:0] oe, early;
        write_word(10'd8, 16'hAAAA, 1'b0, 1'b0, done);
        write_word(10'd8, 16'h1234, 1'b1, 1'b0, done);
        read_word(10'd8, 1'b0, 1'b0, d, oe, early);
        check(d == 16'hAA34, "R3 upper lane masked", 32'(d), 32'hAA34);
        write_word(10'd8, 16'h5678, 1'b0, 1'b1, done);
        read_word(10'd8, 1'b0, 1'b0, d, oe, early);
        check(d == 16'h5634, "R3 lower lane masked", 32'(d), 32'h5634);
    endtask

    task automatic t_last_data();
        logic [15:0] d; logic [1:0] oe, early;
        addr = 10'd5; dq_in = 16'h1111; ce_n = 1'b0; we_n = 1'b0;
        @(negedge clk);
        dq_in = 16'h2222;
        @(negedge clk);
        check(!write_done, "R4 no pulse while strobe active", 32'(write_done), 0);
        we_n = 1'b1;
        @(negedge clk);
        check(write_done, "R4 pulse after end", 32'(write_done), 1);
        ce_n = 1'b1;
        @(negedge clk);
        check(!write_done, "R4 pulse one cycle", 32'(write_done), 0);
        read_word(10'd5, 1'b0, 1'b0, d, oe, early);
        check(d == 16'h2222, "R4 last active data", 32'(d), 32'h2222);
    endtask

    task automatic t_ce_end();
        logic [15:0] d; logic [1:0] oe, early;
        addr = 10'd6; dq_in = 16'h6C6C; ce_n = 1'b0; we_n = 1'b0;
        @(negedge clk);
        ce_n = 1'b1;
        @(negedge clk);
        check(write_done, "R11 ce_n ends write", 32'(write_done), 1);
        we_n = 1'b1;
        @(negedge clk);
        read_word(10'd6, 1'b0, 1'b0, d, oe, early);
        check(d == 16'h6C6C, "R11 data committed", 32'(d), 32'h6C6C);
    endtask

    task automatic t_addr_change();
        addr = 10'd3; ce_n = 1'b0; oe_n = 1'b0;
        repeat (RD_LAT + 1) @(negedge clk);
        check(dq_out == 16'hA55A, "R5 first word", 32'(dq_out), 32'hA55A);
        addr = 10'd5;
        @(negedge clk);
        check(dq_oe == 2'b00, "R5 drive off after move", 32'(dq_oe), 0);
        repeat (RD_LAT) @(negedge clk);
        check(dq_oe == 2'b11 && dq_out == 16'h2222, "R5 new word",
              {14'd0, dq_oe, dq_out}, {14'd0, 2'b11, 16'h2222});
        oe_n = 1'b1;
        @(negedge clk);
        check(dq_oe == 2'b00, "R6 oe_n high", 32'(dq_oe), 0);
        oe_n = 1'b0;
        repeat (RD_LAT + 1) @(negedge clk);
        busy_n = 1'b0;
        @(negedge clk);
        check(dq_oe == 2'b00, "R6 busy_n low", 32'(dq_oe), 0);
        busy_n = 1'b1;
        idle_bus();
        @(negedge clk);
    endtask

    task automatic t_lane_oe();
        logic [15:0] d; logic [1:0] oe, early;
        read_word(10'd3, 1'b0, 1'b1, d, oe, early);
        check(oe == 2'b10 && d[15:8] == 8'hA5, "R7 lower lane off",
              {14'd0, oe, d}, {14'd0, 2'b10, 8'hA5, 8'h00});
    endtask

    task automatic t_busy_write();
        logic done; logic [15:0] d; logic [1:0] oe, early;
        write_word(10'd7, 16'h7777, 1'b0, 1'b0, done);
        busy_n = 1'b0;
        write_word(10'd7, 16'h0BAD, 1'b0, 1'b0, done);
        check(!done, "R8 no write_done while busy", 32'(done), 0);
        busy_n = 1'b1;
        @(negedge clk);
        read_word(10'd7, 1'b0, 1'b0, d, oe, early);
        check(d == 16'h7777, "R8 word unchanged", 32'(d), 32'h7777);
    endtask

    task automatic t_busy_read();
        busy_n = 1'b0; addr = 10'd7; ce_n = 1'b0; oe_n = 1'b0;
        repeat (RD_LAT + 3) @(negedge clk);
        check(dq_oe == 2'b00, "R9 no drive while busy", 32'(dq_oe), 0);
        busy_n = 1'b1;
        repeat (RD_LAT + 1) @(negedge clk);
        check(dq_oe == 2'b11 && dq_out == 16'h7777, "R9 read after busy",
              {14'd0, dq_oe, dq_out}, {14'd0, 2'b11, 16'h7777});
        idle_bus();
        @(negedge clk);
    endtask

    task automatic t_busy_mid_write();
        logic [15:0] d; logic [1:0] oe, early;
        addr = 10'd9; dq_in = 16'h9999; ce_n = 1'b0; we_n = 1'b0;
        @(negedge clk);
        busy_n = 1'b0;
        @(negedge clk);
        we_n = 1'b1;
        @(negedge clk);
        check(write_done, "R10 write finishes under busy", 32'(write_done), 1);
        idle_bus();
        busy_n = 1'b1;
        @(negedge clk);
        read_word(10'd9, 1'b0, 1'b0, d, oe, early);
        check(d == 16'h9999, "R10 data committed", 32'(d), 32'h9999);
    endtask

    task automatic t_addr_span();
        logic done; logic [15:0] d; logic [1:0] oe, early;
        write_word({ADDR_W{1'b1}}, 16'hBEEF, 1'b0, 1'b0, done);
        write_word('0, 16'h0F0F, 1'b0, 1'b0, done);
        read_word({ADDR_W{1'b1}}, 1'b0, 1'b0, d, oe, early);
        check(d == 16'hBEEF, "R12 top word", 32'(d), 32'hBEEF);
        read_word('0, 1'b0, 1'b0, d, oe, early);
        check(d == 16'h0F0F, "R12 word zero", 32'(d), 32'h0F0F);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        t_write_read();
        t_byte_mask();
        t_last_data();
        t_ce_end();
        t_addr_change();
        t_lane_oe();
        t_busy_write();
        t_busy_read();
        t_busy_mid_write();
        t_addr_span();
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule